// File: doc/BRIEF.md
# BCD Calendar Clock with Buffered Register Window

This block keeps a real-time calendar in binary-coded decimal, advanced by a one-second tick input. It tracks seconds, minutes, hours in 24-hour form, day of week, date, month, and a four-digit year held as a year byte and a century byte. Month lengths follow the calendar, and leap years follow the Gregorian rule.

Software reaches the clock through a 16-entry register window on a simple synchronous bus. The running counters are never read or written directly. A second, user-visible copy of the eight time fields stands between the bus and the counters. A flags register holds two control bits. The freeze bit holds the visible copy steady so a multi-byte read is coherent while the counters keep advancing. The set bit holds the visible copy and opens it to writes. When the set bit is cleared, the visible values are loaded into the running counters in a single cycle.

Top module: `bcd_rtc`

## Requirements
- R1: The window decodes byte offsets as follows. Offset 0 is the flags register, with bit 0 the freeze bit and bit 1 the set bit. Offsets 1 to 8 are seconds, minutes, hours, weekday, date, month, year and century. Offsets 9 to 15 read 0. Undefined field bits read 0; the valid-bit masks are 7F, 7F, 3F, 07, 3F, 1F, FF and FF, and the flags mask is 03. Read data updates on the clock edge that samples the read enable and holds otherwise.
- R2: After reset, both flags are 0 and the time is century 20, year 00, month 01, date 01, weekday 1, 00:00:00.
- R3: While the freeze bit is 1 and the set bit is 0, the visible registers do not change, and the running counters keep advancing on every tick.
- R4: When the freeze bit is written to 0 with the set bit 0, the whole visible copy equals the live count from that edge onward, so the next read returns the current time.
- R5: While the set bit is 1, the visible copy does not follow the counters and accepts writes. While the set bit is 0, writes to offsets 1 to 8 have no effect.
- R6: Clearing the set bit loads every visible field into the running counters at once. Counts accumulated while the set bit was 1 are discarded. A tick in the same cycle as the clear is applied to the loaded value.
- R7: Seconds and minutes roll over from 59 to 00, and hours from 23 to 00, each carrying into the next field.
- R8: The weekday counts 1 to 7, returns to 1, and advances at every midnight independently of the date.
- R9: The date rolls over after 31, 30 or 28/29 according to the month. February has 29 days when the year is divisible by 4. A year ending in 00 is a leap year only when the century is divisible by 4.
- R10: Month 12 rolls to 01 and carries into the year. Year 99 rolls to 00 and carries into the century. 9999 wraps to 0000.
- R11: A field nibble loaded with a value above 9 counts upward through F and wraps to 0 without carrying. Normal BCD counting resumes after the wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse that advances the time by one second |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write enable |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | DATA_W | Read data |

## Verification
The bench targets the calendar boundaries: leap and non-leap Februaries, a century year that is not a leap year, year 2000, the 30-day months, and the 9999 wrap. A design that got the leap rule wrong would land on the wrong day of March. A design that carried the wrong way at the century would show a bad year byte. The bench also goes after the handshakes. A set-bit clear that coincides with a tick catches a design that drops that second or adds the counts made during the set window. A freeze release checks that the time did not lose the ticks that arrived while frozen. Loaded nibbles such as 5A seconds and 2A hours expose a design that carries early or clamps invalid values.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   localparam int NFLD  = 8;
   localparam int F_SEC = 0;
   localparam int F_MIN = 1;
   localparam int F_HR  = 2;
   localparam int F_WDY = 3;
   localparam int F_DAT = 4;
   localparam int F_MON = 5;
   localparam int F_YR  = 6;
   localparam int F_CEN = 7;

   typedef logic [NFLD-1:0][7:0] tvec_t;

   // valid bits per field, century down to seconds
   localparam tvec_t FMASK = {8'hFF, 8'hFF, 8'h1F, 8'h3F, 8'h07, 8'h3F, 8'h7F, 8'h7F};

   // one BCD step: low nibble above 9 runs to F then wraps without carry
   function automatic logic [7:0] bcd_step(input logic [7:0] v, input logic [7:0] m);
      logic [3:0] lo;
      logic [3:0] hi;
      lo = v[3:0];
      hi = v[7:4];
      if (lo == 4'd9) begin
         lo = 4'd0;
         hi = hi + 4'd1;
      end else begin
         lo = lo + 4'd1;
      end
      return {hi, lo} & m;
   endfunction

   function automatic logic bcd_div4(input logic [7:0] v);
      logic [5:0] s;
      s = {1'b0, v[7:4], 1'b0} + {2'b00, v[3:0]};
      return (s[1:0] == 2'b00);
   endfunction

   function automatic logic is_leap(input logic [7:0] yr, input logic [7:0] cen);
      if (yr == 8'h00) return bcd_div4(cen);
      return bcd_div4(yr);
   endfunction

   function automatic logic [7:0] month_days(input logic [7:0] mon, input logic leap);
      case (mon)
         8'h02:                      return leap ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

   function automatic tvec_t advance(input tvec_t t);
      tvec_t n;
      n = t;
      if (t[F_SEC] != 8'h59) n[F_SEC] = bcd_step(t[F_SEC], FMASK[F_SEC]);
      else begin
         n[F_SEC] = 8'h00;
         if (t[F_MIN] != 8'h59) n[F_MIN] = bcd_step(t[F_MIN], FMASK[F_MIN]);
         else begin
            n[F_MIN] = 8'h00;
            if (t[F_HR] != 8'h23) n[F_HR] = bcd_step(t[F_HR], FMASK[F_HR]);
            else begin
               n[F_HR]  = 8'h00;
               n[F_WDY] = (t[F_WDY] == 8'h07) ? 8'h01 : ((t[F_WDY] + 8'h01) & FMASK[F_WDY]);
               if (t[F_DAT] != month_days(t[F_MON], is_leap(t[F_YR], t[F_CEN])))
                  n[F_DAT] = bcd_step(t[F_DAT], FMASK[F_DAT]);
               else begin
                  n[F_DAT] = 8'h01;
                  if (t[F_MON] != 8'h12) n[F_MON] = bcd_step(t[F_MON], FMASK[F_MON]);
                  else begin
                     n[F_MON] = 8'h01;
                     if (t[F_YR] != 8'h99) n[F_YR] = bcd_step(t[F_YR], FMASK[F_YR]);
                     else begin
                        n[F_YR]  = 8'h00;
                        n[F_CEN] = (t[F_CEN] == 8'h99) ? 8'h00 : bcd_step(t[F_CEN], FMASK[F_CEN]);
                     end
                  end
               end
            end
         end
      end
      return n;
   endfunction

endpackage

// File: rtl/rtc_advance.sv
module rtc_advance
   import rtc_pkg::*;
(
   input  tvec_t cur,
   input  logic  step,
   output tvec_t nxt
);

   always_comb begin
      nxt = step ? advance(cur) : cur;
   end

   always_comb begin
      if (step && cur[F_WDY] == 8'h07 && cur[F_HR] == 8'h23 &&
          cur[F_MIN] == 8'h59 && cur[F_SEC] == 8'h59)
         AST_WDAY_WRAP: assert (nxt[F_WDY] == 8'h01); // R8
   end

endmodule

// File: rtl/rtc_counter.sv
module rtc_counter
   import rtc_pkg::*;
#(
   parameter tvec_t RST_TIME = 64'h2000_0101_0100_0000
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  tick,
   input  logic  load,
   input  tvec_t vis_i,
   output tvec_t cnt_q,
   output tvec_t cnt_d
);

   tvec_t src;

   assign src = load ? vis_i : cnt_q;

   rtc_advance u_adv (
      .cur  (src),
      .step (tick),
      .nxt  (cnt_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= RST_TIME & FMASK;
      else        cnt_q <= cnt_d;
   end

   AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !load) |=> $stable(cnt_q)); // R3

   AST_LOAD_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !tick) |=> (cnt_q == $past(vis_i))); // R6

   AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load && cnt_q[F_SEC] == 8'h59) |=> (cnt_q[F_SEC] == 8'h00)); // R7

endmodule

// File: rtl/rtc_window.sv
module rtc_window
   import rtc_pkg::*;
#(
   parameter int    ADDR_W   = 4,
   parameter int    DATA_W   = 8,
   parameter bit    READ_REG = 1'b1,
   parameter tvec_t RST_TIME = 64'h2000_0101_0100_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              we,
   input  logic              re,
   output logic [DATA_W-1:0] rdata,
   input  tvec_t             cnt_d_i,
   input  tvec_t             cnt_q_i,
   output tvec_t             vis_o,
   output logic              load_o
);

   localparam int NREG = 16;

   logic rd_q, wr_q, rd_d, wr_d, frz_d, we_flags;
   logic [DATA_W-1:0] mux;

   assign we_flags = we && (addr == ADDR_W'(0));
   assign rd_d     = we_flags ? wdata[0] : rd_q;
   assign wr_d     = we_flags ? wdata[1] : wr_q;
   assign frz_d    = rd_d | wr_d;
   assign load_o   = wr_q & ~wr_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q <= 1'b0;
         wr_q <= 1'b0;
      end else begin
         rd_q <= rd_d;
         wr_q <= wr_d;
      end
   end

   for (genvar i = 0; i < NFLD; i++) begin : g_fld
      logic [7:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            r <= RST_TIME[i] & FMASK[i];
         else if (!frz_d)
            r <= cnt_d_i[i];
         else if (wr_q && we && addr == ADDR_W'(i + 1))
            r <= wdata[7:0] & FMASK[i];
      end
      assign vis_o[i] = r;
   end

   always_comb begin
      mux = '0;
      if (addr == ADDR_W'(0)) mux = DATA_W'({wr_q, rd_q});
      for (int k = 0; k < NFLD; k++)
         if (addr == ADDR_W'(k + 1)) mux = DATA_W'(vis_o[k]);
      if (int'(addr) >= NREG) mux = '0;
   end

   if (READ_REG) begin : g_rreg
      logic [DATA_W-1:0] rq;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)  rq <= '0;
         else if (re) rq <= mux;
      end
      assign rdata = rq;
   end else begin : g_rcomb
      assign rdata = mux;
   end

   AST_FREEZE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_q && !wr_q && !we_flags) |=> $stable(vis_o)); // R3

   AST_TRACK_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_q && !wr_q && !we_flags) |=> (vis_o == cnt_q_i)); // R4

   AST_RELEASE_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
      (we_flags && !wdata[0] && !wdata[1]) |=> (vis_o == cnt_q_i)); // R4

   AST_NO_OPEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_q && !wr_q && we && !we_flags) |=> $stable(vis_o)); // R5

endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
   import rtc_pkg::*;
#(
   parameter int    ADDR_W   = 4,
   parameter int    DATA_W   = 8,
   parameter bit    READ_REG = 1'b1,
   parameter tvec_t RST_TIME = 64'h2000_0101_0100_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sec_tick,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_we,
   input  logic              bus_re,
   output logic [DATA_W-1:0] bus_rdata
);

   if (ADDR_W < 4) begin : g_bad_addr
      $error("bcd_rtc: ADDR_W must cover 16 registers");
   end
   if (DATA_W != 8) begin : g_bad_data
      $error("bcd_rtc: DATA_W must be 8");
   end

   tvec_t cnt_q, cnt_d, vis;
   logic  load;

   rtc_window #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .READ_REG (READ_REG),
      .RST_TIME (RST_TIME)
   ) u_win (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr    (bus_addr),
      .wdata   (bus_wdata),
      .we      (bus_we),
      .re      (bus_re),
      .rdata   (bus_rdata),
      .cnt_d_i (cnt_d),
      .cnt_q_i (cnt_q),
      .vis_o   (vis),
      .load_o  (load)
   );

   rtc_counter #(
      .RST_TIME (RST_TIME)
   ) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (sec_tick),
      .load  (load),
      .vis_i (vis),
      .cnt_q (cnt_q),
      .cnt_d (cnt_d)
   );

endmodule

// File: tb/sim_bcd_rtc.sv
module sim_bcd_rtc;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sec_tick = 1'b0;
   logic [3:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic       bus_we = 1'b0;
   logic       bus_re = 1'b0;
   logic [7:0] bus_rdata;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   bcd_rtc u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .sec_tick  (sec_tick),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_we    (bus_we),
      .bus_re    (bus_re),
      .bus_rdata (bus_rdata)
   );

   typedef struct packed {
      logic [63:0] start;
      logic [15:0] n;
      logic [63:0] expv;
   } vec_t;

   // byte order: century year month date weekday hour minute second
   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      '{64'h2024_0510_0312_3456, 16'd3,  64'h2024_0510_0312_3459},  // R7
      '{64'h2024_0510_0312_5959, 16'd1,  64'h2024_0510_0313_0000},  // R7
      '{64'h2024_0510_0312_3400, 16'd60, 64'h2024_0510_0312_3500},  // R7
      '{64'h2024_0510_0723_5959, 16'd1,  64'h2024_0511_0100_0000},  // R8
      '{64'h2024_0228_0323_5959, 16'd1,  64'h2024_0229_0400_0000},  // R9
      '{64'h2024_0229_0423_5959, 16'd1,  64'h2024_0301_0500_0000},  // R9
      '{64'h2023_0228_0223_5959, 16'd1,  64'h2023_0301_0300_0000},  // R9
      '{64'h1900_0228_0123_5959, 16'd1,  64'h1900_0301_0200_0000},  // R9
      '{64'h2000_0228_0123_5959, 16'd1,  64'h2000_0229_0200_0000},  // R9
      '{64'h2024_0430_0223_5959, 16'd1,  64'h2024_0501_0300_0000},  // R9
      '{64'h1999_1231_0523_5959, 16'd1,  64'h2000_0101_0600_0000},  // R10
      '{64'h9999_1231_0723_5959, 16'd1,  64'h0000_0101_0100_0000},  // R10
      '{64'h2024_0510_0312_345A, 16'd6,  64'h2024_0510_0312_3450},  // R11
      '{64'h2024_0510_032A_5959, 16'd1,  64'h2024_0510_032B_0000}   // R11
   };

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_re = 1'b1;
      @(negedge clk);
      bus_re = 1'b0;
      d = bus_rdata;
   endtask

   task automatic tick_n(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         sec_tick = 1'b1;
         @(negedge clk);
         sec_tick = 1'b0;
      end
   endtask

   task automatic load_time(input logic [63:0] t);
      bus_write(4'h0, 8'h02);
      for (int i = 0; i < 8; i++) bus_write(4'(i + 1), t[i*8 +: 8]);
      bus_write(4'h0, 8'h00);
   endtask

   task automatic read_time(output logic [63:0] t);
      logic [7:0] b;
      for (int i = 0; i < 8; i++) begin
         bus_read(4'(i + 1), b);
         t[i*8 +: 8] = b;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [63:0] t;
      logic [7:0]  b;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R2 reset state
      bus_read(4'h0, b);
      chk("R2 flags", {56'h0, b}, 64'h0);
      read_time(t);
      chk("R2 time", t, 64'h2000_0101_0100_0000);

      // R1 unused offsets and masks
      bus_read(4'h9, b);
      chk("R1 offset9", {56'h0, b}, 64'h0);
      bus_read(4'hF, b);
      chk("R1 offsetF", {56'h0, b}, 64'h0);
      bus_write(4'h0, 8'hFF);
      bus_read(4'h0, b);
      chk("R1 flags mask", {56'h0, b}, 64'h03);
      bus_write(4'h1, 8'hFF);
      bus_read(4'h1, b);
      chk("R1 sec mask", {56'h0, b}, 64'h7F);
      bus_write(4'h4, 8'hFF);
      bus_read(4'h4, b);
      chk("R1 wday mask", {56'h0, b}, 64'h07);
      bus_write(4'h6, 8'hFF);
      bus_read(4'h6, b);
      chk("R1 month mask", {56'h0, b}, 64'h1F);
      bus_write(4'h0, 8'h00);

      // table of rollover vectors
      for (int v = 0; v < NV; v++) begin
         load_time(VECS[v].start);
         tick_n(int'(VECS[v].n));
         read_time(t);
         chk($sformatf("R7-R11 vector %0d", v), t, VECS[v].expv);
      end

      // R3 freeze while counting, R4 release refresh
      load_time(64'h2024_0510_0312_0000);
      bus_write(4'h0, 8'h01);
      tick_n(65);
      bus_read(4'h1, b);
      chk("R3 frozen sec", {56'h0, b}, 64'h00);
      bus_read(4'h2, b);
      chk("R3 frozen min", {56'h0, b}, 64'h00);
      bus_write(4'h0, 8'h00);
      read_time(t);
      chk("R4 release time", t, 64'h2024_0510_0312_0105);

      // R5 writes ignored without the set bit
      bus_write(4'h1, 8'h33);
      bus_read(4'h1, b);
      chk("R5 open write sec", {56'h0, b}, 64'h05);
      bus_write(4'h0, 8'h01);
      bus_write(4'h2, 8'h44);
      bus_write(4'h0, 8'h00);
      bus_read(4'h2, b);
      chk("R5 frozen write min", {56'h0, b}, 64'h01);

      // R5/R6 set window, discard, tick on clear
      load_time(64'h2024_0510_0312_0000);
      bus_write(4'h0, 8'h02);
      tick_n(7);
      bus_read(4'h1, b);
      chk("R5 set holds visible", {56'h0, b}, 64'h00);
      bus_write(4'h1, 8'h10);
      @(negedge clk);
      bus_addr = 4'h0; bus_wdata = 8'h00; bus_we = 1'b1; sec_tick = 1'b1;
      @(negedge clk);
      bus_we = 1'b0; sec_tick = 1'b0;
      read_time(t);
      chk("R6 load with tick", t, 64'h2024_0510_0312_0011);
      tick_n(2);
      bus_read(4'h1, b);
      chk("R6 counting resumes", {56'h0, b}, 64'h13);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule